// File: doc/BRIEF.md
# Radiation-Hardened Front-End Configuration Test Port

This block is the serial configuration port of a front-end readout chip. A four-wire test access port (clock, mode select, serial in, serial out) walks the standard sixteen-state controller. A four-bit instruction picks the data register that sits between serial in and serial out. Two instructions each reach one 39-bit setup word for an input port (port A or port B). Another reaches a small debug delay word, and another reaches a one-bit upset status. Every other code selects the one-bit bypass path. There is no boundary-scan chain and no separate test-reset pin. The controller returns to its reset state through the mode-select sequence or through the chip reset.

Every storage bit in the block is kept as three copies and read through a 2-of-3 vote. This covers the controller state, the instruction and its shifter, the data shifter, the setup words and the status bit. On every clock the voted value is written back into all three copies, so a single flipped copy is repaired. Whenever any pair of copies disagrees, a sticky upset bit is set. Software reads it through the status instruction and clears it there.

Top module: `fe_cfg_tap`

## Requirements
- R1: Driving `rst_n` low, asynchronously, sets both port words to their default and the debug word to 0. The port default is gate width 1 and amplitude 8 with all other fields 0, which is the word 39'h0084000000. It also sets the instruction to bypass and clears the upset bit.
- R2: The controller follows the standard sixteen-state graph. Five rising `tck` edges with `tms` high bring it to Test-Logic-Reset from any state.
- R3: The instruction is 4 bits, shifted in least significant bit first. Capture-IR loads 4'b0001, which appears on `tdo` during the shift. Test-Logic-Reset selects bypass (4'hF). Codes other than 2, 3, 4 and 5 act as bypass, and an Update-DR under them changes no output.
- R4: Under bypass the data path is one bit long, captures 0, and shows each `tdi` bit on `tdo` one shift later.
- R5: Code 4'h2 selects the port-A word, 39 bits, least significant bit first. Capture-DR loads the current `cfg_a` value. The fields from bit 0 upward are: mask [15:0], signal delay [20:16], clock delay [25:21], gate width [27:26], test-pulse amplitude [31:28], test-pulse fine delay [35:32] and test-pulse coarse delay [38:36].
- R6: Code 4'h3 does the same for the port-B word on `cfg_b`.
- R7: Code 4'h4 selects the 5-bit debug delay word on `dbg_delay`.
- R8: The outputs change only in the cycle after Update-DR under their own instruction. While shifting they hold their old value.
- R9: A single disagreeing copy of a bit does not change the voted output, and the next `tck` edge rewrites it from the vote.
- R10: Any copy disagreement sets the upset bit, and it stays set. Code 4'h5 reads it as a 1-bit register. An Update-DR with bit 0 = 1 clears it, and one with bit 0 = 0 leaves it set. A new disagreement wins over a clear in the same cycle.
- R11: Test-Logic-Reset reached by `tms` leaves the port and debug words unchanged.
- R12: `tdo` is 0 outside the Shift-IR and Shift-DR states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state advances on its rising edge |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data in, least significant bit first |
| tdo | output | 1 | Serial data out, valid in shift states |
| cfg_a | output | 39 | Port-A setup word (fields per R5) |
| cfg_b | output | 39 | Port-B setup word (fields per R5) |
| dbg_delay | output | 5 | Debug delay setting |

## Verification
The bench builds the block with its default widths: a 16-bit mask, 5-bit delays, a 2-bit gate width, 4-bit amplitude and fine delay, and 3-bit coarse delay. This gives 39-bit port words and a 5-bit debug word. At these sizes each port word can be written and read back whole in about fifty clocks. That makes it practical to walk a table of patterns, including all ones and a single set bit, and confirm each capture against the previous write. A single copy of a port-word bit is overridden from the bench to raise a disagreement. This exercises the vote, the sticky bit and its clear.

// File: rtl/fe_cfg_pkg.sv
package fe_cfg_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'h0, ST_RTI    = 4'h1,
    ST_SEL_DR = 4'h2, ST_CAP_DR = 4'h3, ST_SH_DR = 4'h4, ST_EX1_DR = 4'h5,
    ST_PAU_DR = 4'h6, ST_EX2_DR = 4'h7, ST_UPD_DR = 4'h8,
    ST_SEL_IR = 4'h9, ST_CAP_IR = 4'hA, ST_SH_IR = 4'hB, ST_EX1_IR = 4'hC,
    ST_PAU_IR = 4'hD, ST_EX2_IR = 4'hE, ST_UPD_IR = 4'hF
  } tap_st_t;

  localparam int          IR_W       = 4;
  localparam logic [3:0]  IR_CAPTURE = 4'b0001;
  localparam logic [3:0]  OP_PORT_A  = 4'h2;
  localparam logic [3:0]  OP_PORT_B  = 4'h3;
  localparam logic [3:0]  OP_DEBUG   = 4'h4;
  localparam logic [3:0]  OP_STATUS  = 4'h5;
  localparam logic [3:0]  OP_BYPASS  = 4'hF;

  // 2-of-3 majority, bitwise
  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  function automatic tap_st_t tap_next(tap_st_t s, logic tms);
    case (s)
      ST_TLR:    return tms ? ST_TLR    : ST_RTI;
      ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return tms ? ST_SEL_DR : ST_RTI;
      default:   return ST_TLR;
    endcase
  endfunction

endpackage

// File: rtl/fe_cfg_tmr.sv
// Triple-copy register with voted read-back and scrub on every edge.
module fe_cfg_tmr import fe_cfg_pkg::*; #(
  parameter int             W    = 1,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         err
);
  logic [W-1:0] c0, c1, c2;
  logic [W-1:0] nxt;

  always_comb begin
    for (int i = 0; i < W; i++) q[i] = maj3(c0[i], c1[i], c2[i]);
  end

  assign err = |((c0 ^ c1) | (c1 ^ c2));
  assign nxt = ld ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0 <= INIT;
      c1 <= INIT;
      c2 <= INIT;
    end else begin
      c0 <= nxt;
      c1 <= nxt;
      c2 <= nxt;
    end
  end
endmodule

// File: rtl/fe_cfg_fsm.sv
// Test-port controller with voted state.
module fe_cfg_fsm import fe_cfg_pkg::*; (
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_t st,
  output logic    err
);
  logic [3:0] st_raw;
  logic [3:0] st_nxt;

  assign st     = tap_st_t'(st_raw);
  assign st_nxt = tap_next(st, tms);

  fe_cfg_tmr #(.W(4), .INIT(ST_TLR)) u_st (
    .clk(tck), .rst_n(rst_n), .ld(1'b1), .d(st_nxt), .q(st_raw), .err(err)
  );
endmodule

// File: rtl/fe_cfg_tap.sv
module fe_cfg_tap import fe_cfg_pkg::*; #(
  parameter int  MASK_W   = 16,
  parameter int  SDLY_W   = 5,
  parameter int  CDLY_W   = 5,
  parameter int  GATE_W   = 2,
  parameter int  AMP_W    = 4,
  parameter int  FINE_W   = 4,
  parameter int  COARSE_W = 3,
  parameter int  DBG_W    = 5,
  parameter int  GATE_DEF = 1,
  parameter int  AMP_DEF  = 8,
  localparam int PCFG_W   = MASK_W + SDLY_W + CDLY_W + GATE_W + AMP_W + FINE_W + COARSE_W
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [PCFG_W-1:0] cfg_a,
  output logic [PCFG_W-1:0] cfg_b,
  output logic [DBG_W-1:0]  dbg_delay
);
  localparam int SR_W = (PCFG_W > DBG_W) ? PCFG_W : DBG_W;
  localparam logic [PCFG_W-1:0] PORT_DEF = {
    COARSE_W'(0), FINE_W'(0), AMP_W'(AMP_DEF), GATE_W'(GATE_DEF),
    CDLY_W'(0), SDLY_W'(0), MASK_W'(0)
  };

  // Shift toward bit 0; the new bit enters at the top of the active length.
  function automatic logic [SR_W-1:0] dr_shift(logic [SR_W-1:0] sr, logic b, int len);
    logic [SR_W:0]   ext;
    logic [SR_W-1:0] r;
    ext = {1'b0, sr};
    for (int i = 0; i < SR_W; i++) begin
      if (i == len - 1)     r[i] = b;
      else if (i < len - 1) r[i] = ext[i+1];
      else                  r[i] = 1'b0;
    end
    return r;
  endfunction

  // controller and named state events
  tap_st_t st;
  logic    st_err;
  fe_cfg_fsm u_ctl (.tck(tck), .rst_n(rst_n), .tms(tms), .st(st), .err(st_err));

  logic in_tlr, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
  assign in_tlr = (st == ST_TLR);
  assign cap_ir = (st == ST_CAP_IR);
  assign sh_ir  = (st == ST_SH_IR);
  assign upd_ir = (st == ST_UPD_IR);
  assign cap_dr = (st == ST_CAP_DR);
  assign sh_dr  = (st == ST_SH_DR);
  assign upd_dr = (st == ST_UPD_DR);

  // instruction shifter and instruction
  logic [IR_W-1:0] ir_sr, ir_q, ir_sr_d, ir_d;
  logic            irsr_err, ir_err;
  assign ir_sr_d = cap_ir ? IR_CAPTURE : {tdi, ir_sr[IR_W-1:1]};
  assign ir_d    = in_tlr ? OP_BYPASS : ir_sr;

  fe_cfg_tmr #(.W(IR_W), .INIT(IR_CAPTURE)) u_irsr (
    .clk(tck), .rst_n(rst_n), .ld(cap_ir | sh_ir), .d(ir_sr_d), .q(ir_sr), .err(irsr_err)
  );
  fe_cfg_tmr #(.W(IR_W), .INIT(OP_BYPASS)) u_ir (
    .clk(tck), .rst_n(rst_n), .ld(upd_ir | in_tlr), .d(ir_d), .q(ir_q), .err(ir_err)
  );

  // instruction decode
  logic sel_a, sel_b, sel_dbg, sel_stat;
  assign sel_a    = (ir_q == OP_PORT_A);
  assign sel_b    = (ir_q == OP_PORT_B);
  assign sel_dbg  = (ir_q == OP_DEBUG);
  assign sel_stat = (ir_q == OP_STATUS);

  logic flag_q;
  int   dr_len;
  logic [SR_W-1:0] cap_val;
  always_comb begin
    dr_len  = 1;
    cap_val = '0;
    if (sel_a) begin
      dr_len = PCFG_W;  cap_val[PCFG_W-1:0] = cfg_a;
    end else if (sel_b) begin
      dr_len = PCFG_W;  cap_val[PCFG_W-1:0] = cfg_b;
    end else if (sel_dbg) begin
      dr_len = DBG_W;   cap_val[DBG_W-1:0] = dbg_delay;
    end else if (sel_stat) begin
      cap_val[0] = flag_q;
    end
  end

  // data shifter
  logic [SR_W-1:0] dr_sr, dr_sr_d;
  logic            dr_err;
  assign dr_sr_d = cap_dr ? cap_val : dr_shift(dr_sr, tdi, dr_len);

  fe_cfg_tmr #(.W(SR_W), .INIT('0)) u_drsr (
    .clk(tck), .rst_n(rst_n), .ld(cap_dr | sh_dr), .d(dr_sr_d), .q(dr_sr), .err(dr_err)
  );

  // update registers
  logic a_err, b_err, dbg_err;
  fe_cfg_tmr #(.W(PCFG_W), .INIT(PORT_DEF)) u_reg_a (
    .clk(tck), .rst_n(rst_n), .ld(upd_dr & sel_a), .d(dr_sr[PCFG_W-1:0]), .q(cfg_a), .err(a_err)
  );
  fe_cfg_tmr #(.W(PCFG_W), .INIT(PORT_DEF)) u_reg_b (
    .clk(tck), .rst_n(rst_n), .ld(upd_dr & sel_b), .d(dr_sr[PCFG_W-1:0]), .q(cfg_b), .err(b_err)
  );
  fe_cfg_tmr #(.W(DBG_W), .INIT('0)) u_reg_dbg (
    .clk(tck), .rst_n(rst_n), .ld(upd_dr & sel_dbg), .d(dr_sr[DBG_W-1:0]), .q(dbg_delay), .err(dbg_err)
  );

  // sticky upset bit: set wins over clear
  logic flag_err, any_err, flag_clr;
  assign any_err  = st_err | irsr_err | ir_err | dr_err | a_err | b_err | dbg_err | flag_err;
  assign flag_clr = upd_dr & sel_stat & dr_sr[0];

  fe_cfg_tmr #(.W(1), .INIT(1'b0)) u_flag (
    .clk(tck), .rst_n(rst_n), .ld(any_err | flag_clr), .d(any_err), .q(flag_q), .err(flag_err)
  );

  assign tdo = sh_ir ? ir_sr[0] : (sh_dr ? dr_sr[0] : 1'b0);

endmodule

// File: rtl/fe_cfg_tap_chk.sv
module fe_cfg_tap_chk import fe_cfg_pkg::*; #(
  parameter int PCFG_W = 39,
  parameter int DBG_W  = 5
) (
  input logic              tck,
  input logic              rst_n,
  input logic              tms,
  input logic              tdo,
  input tap_st_t           st,
  input logic [3:0]        ir_q,
  input logic [3:0]        ir_sr,
  input logic              upd_dr,
  input logic              flag_q,
  input logic              flag_clr,
  input logic              any_err,
  input logic [PCFG_W-1:0] cfg_a,
  input logic [PCFG_W-1:0] cfg_b,
  input logic [DBG_W-1:0]  dbg_delay
);
  logic [2:0] ones;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ones <= '0;
    else if (tms)   ones <= (ones == 3'd5) ? 3'd5 : ones + 3'd1;
    else            ones <= '0;
  end

  assert_five_ones_tlr_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (ones == 3'd5) |-> (st == ST_TLR));

  assert_ir_reset_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_TLR) |=> (ir_q == OP_BYPASS));

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  assert_hold_a_R8: assert property (@(posedge tck) disable iff (!rst_n)
    !upd_dr |=> $stable(cfg_a));

  assert_hold_b_R8: assert property (@(posedge tck) disable iff (!rst_n)
    !upd_dr |=> $stable(cfg_b));

  assert_hold_dbg_R8: assert property (@(posedge tck) disable iff (!rst_n)
    !upd_dr |=> $stable(dbg_delay));

  assert_flag_set_R10: assert property (@(posedge tck) disable iff (!rst_n)
    any_err |=> flag_q);

  assert_flag_sticky_R10: assert property (@(posedge tck) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  assert_tdo_idle_R12: assert property (@(posedge tck) disable iff (!rst_n)
    !(st == ST_SH_IR || st == ST_SH_DR) |-> !tdo);
endmodule

bind fe_cfg_tap fe_cfg_tap_chk #(.PCFG_W(PCFG_W), .DBG_W(DBG_W)) u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .tdo(tdo), .st(st), .ir_q(ir_q), .ir_sr(ir_sr),
  .upd_dr(upd_dr), .flag_q(flag_q), .flag_clr(flag_clr), .any_err(any_err),
  .cfg_a(cfg_a), .cfg_b(cfg_b), .dbg_delay(dbg_delay)
);

// File: tb/fe_cfg_tap_tb.sv
`timescale 1ns/1ps
module fe_cfg_tap_tb;
  localparam int          LEN_P  = 39;
  localparam int          LEN_D  = 5;
  localparam logic [63:0] DEF_P  = 64'h00_8400_0000;
  localparam logic [3:0]  C_A = 4'h2, C_B = 4'h3, C_D = 4'h4, C_S = 4'h5, C_X = 4'h7;

  typedef struct packed {
    logic [3:0]  op;
    logic [63:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'h2, 64'h5A_1234_ABCD},
    '{4'h3, 64'h7F_FFFF_FFFF},
    '{4'h4, 64'h13},
    '{4'h2, 64'h00_0000_0001},
    '{4'h4, 64'h1F},
    '{4'h3, 64'h12_3456_789A}
  };

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo;
  logic [38:0] cfg_a, cfg_b;
  logic [4:0]  dbg_delay;

  fe_cfg_tap u_dut (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .dbg_delay(dbg_delay)
  );

  always #2 tck = ~tck;

  int total = 0, bad = 0;
  logic done = 1'b0;
  logic [63:0] mdl_a = DEF_P, mdl_b = DEF_P, mdl_d = 64'h0;
  logic [63:0] mid_a, mid_b, mid_d;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic i, output logic o);
    @(negedge tck);
    tms = m;
    tdi = i;
    #1;
    o = tdo;
  endtask

  task automatic settle();
    @(posedge tck);
    #1;
  endtask

  task automatic reset_tap();
    logic o;
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    settle();
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
    logic o;
    step(1'b1, 1'b0, o); step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int k = 0; k < 4; k++) begin
      step(k == 3, code[k], o);
      cap[k] = o;
    end
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    settle();
  endtask

  task automatic shift_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int k = 0; k < len; k++) begin
      step(k == len - 1, din[k], o);
      dout[k] = o;
    end
    step(1'b1, 1'b0, o);
    mid_a = 64'(cfg_a); mid_b = 64'(cfg_b); mid_d = 64'(dbg_delay);
    step(1'b0, 1'b0, o);
    settle();
  endtask

  function automatic logic [63:0] byp_exp(logic [63:0] din, int len);
    return (din << 1) & ((64'h1 << len) - 64'h1);
  endfunction

  initial begin
    repeat (60000) @(posedge tck);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (R1..all) act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0]  cap;
    logic [63:0] q, prev, d;
    logic        o;
    int          len;
    string       tag;

    // R1: reset values while reset held; R12: idle tdo
    repeat (3) @(negedge tck);
    #1;
    chk("R1 cfg_a default", 64'(cfg_a), DEF_P);
    chk("R1 cfg_b default", 64'(cfg_b), DEF_P);
    chk("R1 dbg default", 64'(dbg_delay), 64'h0);
    chk("R12 tdo in reset", 64'(tdo), 64'h0);
    rst_n = 1'b1;
    reset_tap();
    chk("R12 tdo idle in RTI", 64'(tdo), 64'h0);

    // R1/R4: instruction after reset is bypass
    shift_dr(8, 64'hA5, q);
    chk("R4 bypass after reset", q, byp_exp(64'hA5, 8));

    // R10: status clear after reset
    shift_ir(C_S, cap);
    shift_dr(1, 64'h0, q);
    chk("R1 upset bit clear after reset", q, 64'h0);

    // table of writes and read-backs: R5 R6 R7 R8 R3
    for (int v = 0; v < 6; v++) begin
      shift_ir(VECS[v].op, cap);
      chk("R3 IR capture 0001", 64'(cap), 64'h1);
      if (VECS[v].op == C_A)      begin len = LEN_P; prev = mdl_a; tag = "R5"; end
      else if (VECS[v].op == C_B) begin len = LEN_P; prev = mdl_b; tag = "R6"; end
      else                        begin len = LEN_D; prev = mdl_d; tag = "R7"; end
      d = VECS[v].data & ((64'h1 << len) - 64'h1);
      shift_dr(len, d, q);
      chk({tag, " capture old value"}, q, prev);
      chk("R8 port A held during shift", mid_a, mdl_a);
      chk("R8 port B held during shift", mid_b, mdl_b);
      chk("R8 debug held during shift", mid_d, mdl_d);
      if (VECS[v].op == C_A)      mdl_a = d;
      else if (VECS[v].op == C_B) mdl_b = d;
      else                        mdl_d = d;
      chk({tag, " port A after update"}, 64'(cfg_a), mdl_a);
      chk({tag, " port B after update"}, 64'(cfg_b), mdl_b);
      chk({tag, " debug after update"}, 64'(dbg_delay), mdl_d);
    end

    // R3/R4: unlisted code acts as bypass, update touches nothing
    shift_ir(C_X, cap);
    shift_dr(8, 64'h3C, q);
    chk("R3 unlisted code bypass path", q, byp_exp(64'h3C, 8));
    chk("R3 unlisted code port A unchanged", 64'(cfg_a), mdl_a);
    chk("R3 unlisted code port B unchanged", 64'(cfg_b), mdl_b);
    chk("R3 unlisted code debug unchanged", 64'(dbg_delay), mdl_d);

    // R2/R11: five TMS-high from Pause-DR reach reset, config kept
    shift_ir(C_A, cap);
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    settle();
    chk("R11 port A kept across TAP reset", 64'(cfg_a), mdl_a);
    chk("R11 debug kept across TAP reset", 64'(dbg_delay), mdl_d);
    shift_dr(8, 64'hC3, q);
    chk("R2 five ones reset IR to bypass", q, byp_exp(64'hC3, 8));

    // R9/R10: upset one copy of port A
    shift_ir(C_S, cap);
    @(negedge tck);
    force u_dut.u_reg_a.c1 = ~mdl_a[38:0];
    @(posedge tck);
    #1;
    release u_dut.u_reg_a.c1;
    settle();
    settle();
    chk("R9 voted port A unaffected by one copy", 64'(cfg_a), mdl_a);
    shift_dr(1, 64'h0, q);
    chk("R10 upset bit set", q, 64'h1);
    shift_dr(1, 64'h1, q);
    chk("R10 upset bit sticky after write 0", q, 64'h1);
    shift_dr(1, 64'h0, q);
    chk("R10 upset bit cleared by write 1", q, 64'h0);
    chk("R9 port A still correct after scrub", 64'(cfg_a), mdl_a);

    // R1: chip reset mid-run
    @(negedge tck);
    rst_n = 1'b0;
    repeat (2) @(negedge tck);
    #1;
    chk("R1 port A default after chip reset", 64'(cfg_a), DEF_P);
    chk("R1 port B default after chip reset", 64'(cfg_b), DEF_P);
    chk("R1 debug default after chip reset", 64'(dbg_delay), 64'h0);
    rst_n = 1'b1;
    reset_tap();
    shift_dr(4, 64'h9, q);
    chk("R1 IR bypass after chip reset", q, byp_exp(64'h9, 4));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule